// File: doc/BRIEF.md
# Register-Driven SPI Transaction Sequencer

This block is an SPI master that runs one whole half-duplex transaction from values the host has placed in its registers beforehand. Each transaction has up to three phases in a fixed order: a command of up to 32 bits taken from an opcode register, then an optional outgoing stream taken from a bank of data words, then an optional incoming stream that is written back into the same data words. A single packed register gives the bit count of every phase, and a phase whose count is zero is skipped.

The host talks to the block over a simple 32-bit register bus with a write strobe and a combinational read path. It fills the opcode, the data words, the clock divider and the bit counts, drives chip select through its own register bit, launches the transaction with a start bit and polls a busy flag until the transaction is over. The serial clock idles low, the outgoing line changes after a falling edge, and the incoming line is sampled on the rising edge.

Top module: `spi_txn_engine`

## Requirements
- R1: After reset the busy flag (control register at 0x00, bit 16) is 0, `spi_sck` is 0, `spi_mosi` is 0, `spi_cs_n` is 1 and the configuration register at 0x28 reads 0x000D0000 (divider field bits [27:16] equal to 13).
- R2: A bus write to 0x00 with bit 8 set launches a transaction, and bit 16 of 0x00 reads 1 on the next cycle. If all three phase counts are zero, bit 16 stays 0.
- R3: `spi_sck` idles low. Each SCK half period lasts D+2 system clocks, where D is the divider field of 0x28. Busy stays high for exactly 2*(D+2)*N cycles, where N is the total number of bits, and SCK is high for (D+2)*N of those cycles.
- R4: Phases run in the order command, outgoing data, incoming data. A command of C bits sends opcode register (0x04) bits C-1 down to 0, most significant first.
- R5: In the outgoing phase, stream byte n comes from data word n/4 (word k at 0x08+4k) bits [8*(n mod 4)+7 : 8*(n mod 4)], and each byte is sent most significant bit first.
- R6: In the incoming phase, `spi_mosi` is 0. Received bit j is stored in data word j/32 at bit 8*((j/8) mod 4)+7-(j mod 8), so the first received byte lands in bits [7:0] of word 0. Data-word bits that are not received keep their values.
- R7: A phase whose count is zero produces no SCK pulse. The number of SCK rising edges in a transaction equals the sum of the effective phase counts.
- R8: A start write while busy is 1 is ignored: the running transaction keeps its length and its bit stream.
- R9: `spi_cs_n` is the inverse of bit 0 of the register at 0x38. It changes only when that register is written, and never because a transaction starts or ends.
- R10: The count register at 0x2C holds the command count in bits [29:24], the incoming count in bits [20:12] and the outgoing count in bits [8:0]. It reads back the written value ANDed with 0x3F1FF1FF. The configuration register reads back the written value ANDed with 0xEFFF0004.
- R11: A command count above 32 is treated as 32, and an outgoing or incoming count above 256 is treated as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong phase or bit index in the sequencer shows up on `spi_mosi` at the very next SCK rising edge, as a mismatch against the bit stream expected from the opcode and the data words. A corrupted capture index shows up as soon as the data words are read back after busy drops. A divider or tick-counter fault changes the busy length and the SCK high time, which are measured to the exact cycle. A fault in phase skipping or in a count shows up as an extra or missing SCK rising edge, and as a busy length that differs by a whole multiple of 2*(D+2) cycles.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

  localparam int CLK_W     = 12;
  localparam int CMD_W     = 6;
  localparam int CMD_MAX   = 32;
  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_OPC  = 8'h04;
  localparam logic [7:0] OFF_DATA = 8'h08;
  localparam logic [7:0] OFF_CFG  = 8'h28;
  localparam logic [7:0] OFF_CNT  = 8'h2C;
  localparam logic [7:0] OFF_CS   = 8'h38;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_WR   = 2'd2,
    PH_RD   = 2'd3
  } phase_e;

  // next non-empty phase after cur, or idle when none remains
  function automatic phase_e phase_after(phase_e cur, logic has_cmd, logic has_wr, logic has_rd);
    phase_e nxt;
    nxt = PH_IDLE;
    case (cur)
      PH_IDLE: nxt = has_cmd ? PH_CMD : (has_wr ? PH_WR : (has_rd ? PH_RD : PH_IDLE));
      PH_CMD:  nxt = has_wr ? PH_WR : (has_rd ? PH_RD : PH_IDLE);
      PH_WR:   nxt = has_rd ? PH_RD : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // system clocks per SCK half period
  function automatic logic [CLK_W:0] half_cycles(logic [CLK_W-1:0] div);
    return {1'b0, div} + (CLK_W+1)'(2);
  endfunction

endpackage

// File: rtl/spi_txn_regs.sv
module spi_txn_regs
  import spi_txn_pkg::*;
#(
  parameter int DW = 8,
  parameter int CNT_W = 9,
  parameter int IDX_W = 8,
  parameter logic [CLK_W-1:0] DIV_RST = 12'd13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             addr,
  input  logic                   wr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  logic                   busy,
  output logic                   start_evt,
  output logic [31:0]            opcode,
  output logic [DW-1:0][31:0]    words,
  output logic [CLK_W-1:0]       div,
  output logic [CMD_W-1:0]       cmd_field,
  output logic [CNT_W-1:0]       wr_field,
  output logic [CNT_W-1:0]       rd_field,
  output logic                   cs_on,
  input  logic                   rx_we,
  input  logic [IDX_W-1:0]       rx_idx,
  input  logic                   rx_bit
);

  localparam logic [31:0] CNT_ONES = (32'h1 << CNT_W) - 32'h1;
  localparam logic [31:0] CFG_MASK = 32'hE000_0004 | (((32'h1 << CLK_W) - 32'h1) << 16);
  localparam logic [31:0] CNT_MASK = (32'h3F << 24) | (CNT_ONES << 12) | CNT_ONES;
  localparam logic [31:0] CFG_RST  = 32'(DIV_RST) << 16;

  logic [31:0]         cfg_q, cnt_q, opc_q;
  logic                cs_q;
  logic [DW-1:0][31:0] words_q;

  assign start_evt = wr && (addr == OFF_CTRL) && wdata[START_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      cnt_q   <= '0;
      opc_q   <= '0;
      cs_q    <= 1'b0;
      words_q <= '0;
    end else begin
      if (wr) begin
        if (addr == OFF_CFG) cfg_q <= wdata & CFG_MASK;
        if (addr == OFF_CNT) cnt_q <= wdata & CNT_MASK;
        if (addr == OFF_OPC) opc_q <= wdata;
        if (addr == OFF_CS)  cs_q  <= wdata[0];
        for (int k = 0; k < DW; k++)
          if (addr == OFF_DATA + 8'(4*k)) words_q[k] <= wdata;
      end
      // received bit: word j/32, byte (j/8)%4, MSB-first inside the byte
      if (rx_we)
        words_q[rx_idx[IDX_W-1:5]][{rx_idx[4:3], ~rx_idx[2:0]}] <= rx_bit;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL: rdata[BUSY_BIT] = busy;
      OFF_OPC:  rdata = opc_q;
      OFF_CFG:  rdata = cfg_q;
      OFF_CNT:  rdata = cnt_q;
      OFF_CS:   rdata[0] = cs_q;
      default: begin
        for (int k = 0; k < DW; k++)
          if (addr == OFF_DATA + 8'(4*k)) rdata = words_q[k];
      end
    endcase
  end

  assign opcode    = opc_q;
  assign words     = words_q;
  assign div       = cfg_q[16 +: CLK_W];
  assign cmd_field = cnt_q[24 +: CMD_W];
  assign rd_field  = cnt_q[12 +: CNT_W];
  assign wr_field  = cnt_q[0 +: CNT_W];
  assign cs_on     = cs_q;

endmodule

// File: rtl/spi_txn_clkgen.sv
module spi_txn_clkgen
  import spi_txn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CLK_W-1:0] div,
  output logic             sck,
  output logic             sck_rise,
  output logic             sck_fall
);

  logic [CLK_W:0] tick_q;
  logic           edge_now;

  assign edge_now = run && (tick_q == half_cycles(div) - (CLK_W+1)'(1));
  assign sck_rise = edge_now && !sck;
  assign sck_fall = edge_now && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      sck    <= 1'b0;
    end else if (!run) begin
      tick_q <= '0;
      sck    <= 1'b0;
    end else if (edge_now) begin
      tick_q <= '0;
      sck    <= ~sck;
    end else begin
      tick_q <= tick_q + (CLK_W+1)'(1);
    end
  end

endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq
  import spi_txn_pkg::*;
#(
  parameter int DW = 8,
  parameter int CNT_W = 9,
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_evt,
  input  logic [CMD_W-1:0]    cmd_n,
  input  logic [CNT_W-1:0]    wr_n,
  input  logic [CNT_W-1:0]    rd_n,
  input  logic                sck_rise,
  input  logic                sck_fall,
  input  logic [31:0]         opcode,
  input  logic [DW-1:0][31:0] words,
  output logic                busy,
  output phase_e              phase,
  output logic                mosi,
  output logic                rx_we,
  output logic [IDX_W-1:0]    rx_idx,
  output logic                last_bit
);

  phase_e           ph_q;
  logic [CNT_W-1:0] idx_q;
  logic [CMD_W-1:0] c_q;
  logic [CNT_W-1:0] w_q, r_q;
  logic [CNT_W-1:0] cur_len;
  logic [4:0]       cmd_sel;

  always_comb begin
    case (ph_q)
      PH_CMD:  cur_len = CNT_W'(c_q);
      PH_WR:   cur_len = w_q;
      PH_RD:   cur_len = r_q;
      default: cur_len = '0;
    endcase
  end

  assign last_bit = (ph_q != PH_IDLE) && (idx_q == cur_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      c_q   <= '0;
      w_q   <= '0;
      r_q   <= '0;
    end else if (start_evt && ph_q == PH_IDLE) begin
      c_q   <= cmd_n;
      w_q   <= wr_n;
      r_q   <= rd_n;
      idx_q <= '0;
      ph_q  <= phase_after(PH_IDLE, cmd_n != '0, wr_n != '0, rd_n != '0);
    end else if (sck_fall && ph_q != PH_IDLE) begin
      if (last_bit) begin
        idx_q <= '0;
        ph_q  <= phase_after(ph_q, c_q != '0, w_q != '0, r_q != '0);
      end else begin
        idx_q <= idx_q + CNT_W'(1);
      end
    end
  end

  assign cmd_sel = 5'(c_q - CMD_W'(1) - idx_q[CMD_W-1:0]);

  always_comb begin
    case (ph_q)
      PH_CMD:  mosi = opcode[cmd_sel];
      PH_WR:   mosi = words[idx_q[IDX_W-1:5]][{idx_q[4:3], ~idx_q[2:0]}];
      default: mosi = 1'b0;
    endcase
  end

  assign busy   = (ph_q != PH_IDLE);
  assign phase  = ph_q;
  assign rx_we  = sck_rise && (ph_q == PH_RD);
  assign rx_idx = idx_q[IDX_W-1:0];

endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
  import spi_txn_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [CLK_W-1:0] DIV_RST = 12'd13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int MAX_BITS = DW * 32;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int IDX_W    = $clog2(MAX_BITS);

  logic                start_evt, busy, cs_on, rx_we, last_bit;
  logic                sck_rise, sck_fall;
  logic [31:0]         opcode;
  logic [DW-1:0][31:0] words;
  logic [CLK_W-1:0]    div;
  logic [CMD_W-1:0]    cmd_field, cmd_n;
  logic [CNT_W-1:0]    wr_field, rd_field, wr_n, rd_n;
  logic [IDX_W-1:0]    rx_idx;
  phase_e              phase;
  logic                in_read, counts_zero;

  // effective counts, saturated at the phase capacity
  assign cmd_n = (cmd_field > CMD_W'(CMD_MAX)) ? CMD_W'(CMD_MAX) : cmd_field;
  assign wr_n  = (wr_field > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : wr_field;
  assign rd_n  = (rd_field > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : rd_field;

  assign in_read     = (phase == PH_RD);
  assign counts_zero = (cmd_n == '0) && (wr_n == '0) && (rd_n == '0);

  spi_txn_regs #(.DW(DW), .CNT_W(CNT_W), .IDX_W(IDX_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .start_evt(start_evt), .opcode(opcode),
    .words(words), .div(div), .cmd_field(cmd_field), .wr_field(wr_field),
    .rd_field(rd_field), .cs_on(cs_on), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_bit(spi_miso)
  );

  spi_txn_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
    .sck(spi_sck), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  spi_txn_seq #(.DW(DW), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .cmd_n(cmd_n),
    .wr_n(wr_n), .rd_n(rd_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .opcode(opcode), .words(words), .busy(busy), .phase(phase),
    .mosi(spi_mosi), .rx_we(rx_we), .rx_idx(rx_idx), .last_bit(last_bit)
  );

  assign spi_cs_n = ~cs_on;

endmodule

// File: rtl/spi_txn_chk.sv
module spi_txn_chk
  import spi_txn_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       spi_cs_n,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic       start_evt,
  input logic       sck_rise,
  input logic       sck_fall,
  input logic       rx_we,
  input logic       in_read,
  input logic       counts_zero
);

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !counts_zero |=> busy);

  // R2
  empty_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && counts_zero |=> !busy);

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  // R3
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise || sck_fall) |=> $stable(spi_sck));

  // R6
  rx_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |=> spi_sck);

  // R6
  read_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |-> !spi_mosi);

  // R7
  rise_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> busy);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !busy);

  // R9
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFF_CS) |=> $stable(spi_cs_n));

endmodule

bind spi_txn_engine spi_txn_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .start_evt(start_evt),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .rx_we(rx_we), .in_read(in_read),
  .counts_zero(counts_zero)
);

// File: tb/sim_spi_txn_engine.sv
module sim_spi_txn_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #5 clk = ~clk;

  spi_txn_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int          checks = 0;
  int          errors = 0;
  logic [31:0] tw [8];
  logic [31:0] g_opc;
  logic [255:0] g_rx;
  int          g_cmd, g_wr, g_rd;
  logic [599:0] cap;
  int          nrise = 0;

  function automatic logic miso_for(int n);
    int p;
    p = g_cmd + g_wr;
    if (n >= p && n - p < 256) return g_rx[n - p];
    return n[0];
  endfunction

  // slave model: record MOSI at each rising SCK, present the next MISO bit after it
  always @(posedge spi_sck) begin
    if (nrise < 600) cap[nrise] = spi_mosi;
    nrise++;
    #1 spi_miso = miso_for(nrise);
  end

  function automatic logic exp_mosi(int n);
    int k, b;
    if (n < g_cmd) return g_opc[g_cmd - 1 - n];
    k = n - g_cmd;
    if (k < g_wr) begin
      b = k / 8;
      return tw[b / 4][(b % 4) * 8 + 7 - (k % 8)];
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_word(int w);
    logic [31:0] v;
    v = tw[w];
    for (int j = 0; j < g_rd; j++)
      if (j / 32 == w) v[((j / 8) % 4) * 8 + 7 - (j % 8)] = g_rx[j];
    return v;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_txn(int cmdf, int wrn, int rdn, int dv, bit poke);
    int cnt, hi, total, mis;
    logic [31:0] rv;
    g_cmd = (cmdf > 32) ? 32 : cmdf;
    g_wr = wrn; g_rd = rdn;
    g_opc = $urandom();
    for (int i = 0; i < 8; i++) g_rx[i*32 +: 32] = $urandom();
    bus_wr(8'h28, 32'(dv) << 16);
    bus_wr(8'h04, g_opc);
    for (int i = 0; i < 8; i++) begin
      tw[i] = $urandom();
      bus_wr(8'(8 + 4*i), tw[i]);
    end
    bus_wr(8'h2C, (32'(cmdf) << 24) | (32'(rdn) << 12) | 32'(wrn));
    nrise = 0;
    spi_miso = miso_for(0);
    bus_wr(8'h00, 32'h100);
    cnt = 0; hi = 0;
    // R2: busy seen on the cycle after the start write
    total = g_cmd + g_wr + g_rd;
    check(reg_rdata[16] == (total != 0), "R2 busy after start", reg_rdata[16], total != 0);
    while (reg_rdata[16] && cnt < 100000) begin
      if (spi_sck) hi++;
      cnt++;
      if (poke && cnt == 3) begin reg_wr = 1'b1; reg_wdata = 32'h100; end
      if (poke && cnt == 4) reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    // R3 busy length and SCK high time
    check(cnt == 2 * (dv + 2) * total, poke ? "R8 length with ignored start" : "R3 busy length",
          cnt, 2 * (dv + 2) * total);
    check(hi == (dv + 2) * total, "R3 sck high time", hi, (dv + 2) * total);
    // R7 rising edge count
    check(nrise == total, "R7 sck rise count", nrise, total);
    // R4 R5 R6 stream order and content
    mis = 0;
    for (int n = 0; n < total && n < 600; n++) if (cap[n] !== exp_mosi(n)) mis++;
    check(mis == 0, "R4 R5 mosi stream", mis, 0);
    for (int w = 0; w < 8; w++) begin
      bus_rd(8'(8 + 4*w), rv);
      check(rv == exp_word(w), "R6 data word after read", rv, exp_word(w));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd1234));
    g_cmd = 0; g_wr = 0; g_rd = 0; g_rx = '0; g_opc = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0; spi_miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(8'h00, rv);
    check(rv[16] == 1'b0, "R1 busy at reset", rv[16], 0);
    check(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 sck/mosi at reset", {spi_sck, spi_mosi}, 0);
    check(spi_cs_n == 1'b1, "R1 cs_n at reset", spi_cs_n, 1);
    bus_rd(8'h28, rv);
    check(rv == 32'h000D_0000, "R1 config reset", rv, 32'h000D_0000);

    // R10 field masks
    bus_wr(8'h2C, 32'hFFFF_FFFF);
    bus_rd(8'h2C, rv);
    check(rv == 32'h3F1F_F1FF, "R10 count readback", rv, 32'h3F1F_F1FF);
    bus_wr(8'h28, 32'hFFFF_FFFF);
    bus_rd(8'h28, rv);
    check(rv == 32'hEFFF_0004, "R10 config readback", rv, 32'hEFFF_0004);

    // R9 chip select under host control only
    bus_wr(8'h38, 32'h1);
    @(negedge clk);
    check(spi_cs_n == 1'b0, "R9 cs asserted", spi_cs_n, 0);

    // R2 zero-count start leaves busy low
    bus_wr(8'h2C, 32'h0);
    nrise = 0;
    bus_wr(8'h00, 32'h100);
    check(reg_rdata[16] == 1'b0, "R2 empty start", reg_rdata[16], 0);
    check(nrise == 0, "R7 empty start no sck", nrise, 0);

    // directed cases
    do_txn(8, 8, 8, 13, 1'b0);     // R3 default divider
    do_txn(32, 256, 256, 0, 1'b0); // full capacity
    do_txn(5, 0, 11, 1, 1'b0);     // R7 write phase skipped, partial bytes
    do_txn(0, 13, 0, 2, 1'b0);     // R7 only outgoing phase
    do_txn(0, 0, 20, 0, 1'b0);     // R6 only incoming phase
    do_txn(40, 4, 0, 0, 1'b0);     // R11 command count saturates at 32
    do_txn(12, 24, 16, 1, 1'b1);   // R8 start while busy ignored
    check(spi_cs_n == 1'b0, "R9 cs unchanged by transactions", spi_cs_n, 0);
    bus_wr(8'h38, 32'h0);
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R9 cs released", spi_cs_n, 1);

    // constrained random transactions
    for (int t = 0; t < 16; t++)
      do_txn($urandom_range(0, 32), $urandom_range(0, 64), $urandom_range(0, 64),
             $urandom_range(0, 3), 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule